// File: doc/BRIEF.md
# Capture/Reload Timer with Up/Down Counting

This block is a 16-bit timer/counter that a processor configures through an 8-bit control register and a 2-bit mode register, and whose count and capture/reload value it reads and writes as bytes. The count advances on a one-cycle machine-cycle tick, or on falling edges of an external count pin that are qualified on those ticks. A second pin acts as a capture or reload trigger, and in up/down operation it selects the count direction.

There are three behaviours. In capture mode the running count is copied into the capture/reload register on a trigger edge. In auto-reload mode a preset value is loaded when the count wraps, and the count may run up or down. In baud mode the count runs freely as a reload divider for a serial port. Two sticky flags, overflow and external, drive one interrupt line. Every wrap produces a one-cycle pulse for the serial clock.

Register select codes on `reg_sel`: 0 is control, 1 is mode, 2 is count low byte, 3 is count high byte, 4 is capture/reload low byte, 5 is capture/reload high byte. Control bits are: 7 overflow flag TF, 6 external flag EXF, 5 and 4 the two baud-clock selects, 3 trigger enable, 2 run, 1 counter select (1 counts pin edges), 0 capture select. Mode bits are: 0 up/down enable, 1 output-enable storage.

Top module: `cr_updown_timer`

## Requirements
- R1: After a synchronous active-low reset, control, mode, count and capture/reload read zero, and `irq` and `ovf_pulse` are low. The `reg_sel` codes and the control and mode bit positions are as listed above.
- R2: When run (control bit 2) is 1 and counter select is 0, the count steps once per cycle in which `mc_tick` is high. It holds while run is 0 or while `mc_tick` is low.
- R3: With counter select (bit 1) set, the count steps once for each tick whose sample of `cnt_pin` is 0 when the previous tick's sample was 1. The sample register is 0 after reset.
- R4: In auto-reload mode (capture select 0, both baud bits 0) counting up, a step from 0xFFFF loads the capture/reload value and sets TF.
- R5: In capture mode with trigger enable (bit 3) set, a trigger falling edge (the same two-sample rule as R3) copies the pre-step count into the capture/reload register and sets EXF. Counting continues, and a step from 0xFFFF goes to 0x0000 and sets TF.
- R6: In auto-reload mode with up/down disabled and trigger enable set, a trigger falling edge loads the capture/reload value and sets EXF. With trigger enable 0, the edge has no effect.
- R7: In auto-reload mode with mode bit 0 set, `trig_pin` high counts up and low counts down. A down step with the count equal to the capture/reload value loads 0xFFFF and sets TF. EXF toggles on every wrap in either direction, and trigger edges cause no reload.
- R8: When either baud bit is set, the count reloads on overflow regardless of capture select, TF is never set, and trigger edges neither capture nor set EXF.
- R9: `irq` is TF OR (EXF AND NOT mode bit 0). Both flags stay set until a control write clears them.
- R10: `ovf_pulse` is high for exactly the cycle after each step that wraps, in either direction and in any mode.
- R11: A processor write to a count byte in the same cycle as a step sets that byte to the written value. The other byte takes its stepped value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_tick | input | 1 | One-cycle machine-cycle tick |
| cnt_pin | input | 1 | External count input |
| trig_pin | input | 1 | Capture/reload trigger and direction input |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 8 | Register write data |
| ctl_q | output | 8 | Control register |
| mode_q | output | 2 | Mode register |
| count_q | output | 16 | Current count |
| reload_q | output | 16 | Capture/reload register |
| irq | output | 1 | Interrupt request |
| ovf_pulse | output | 1 | One-cycle wrap pulse |

## Verification
The count is swept tick by tick across several wraps in auto-reload, up/down and baud modes, and is compared with closed-form modular arithmetic. This separates a reload from a wrap to zero, and separates the two down-count floors. Count-pin bit patterns with different densities of high-to-low pairs distinguish edge counting from level counting, and they also catch a sampler that misses edges lying across pattern boundaries. Trigger edges are applied in every mode, with and without trigger enable, so that capture, reload, direction-only and ignored behaviour each produce a different count or capture value. Ticks that carry a byte write show which source takes priority.

// File: rtl/crt_pkg.sv
// Shared types for the capture/reload timer.
// Assumes an 8-bit control register and byte-wide register access.
package crt_pkg;
    typedef enum logic [2:0] {
        SEL_CTL    = 3'd0,
        SEL_MODE   = 3'd1,
        SEL_CNT_LO = 3'd2,
        SEL_CNT_HI = 3'd3,
        SEL_RLD_LO = 3'd4,
        SEL_RLD_HI = 3'd5
    } crt_sel_e;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_RELOAD  = 2'd1,
        MODE_CAPTURE = 2'd2,
        MODE_BAUD    = 2'd3
    } crt_mode_e;

    localparam int CTL_TF   = 7;
    localparam int CTL_EXF  = 6;
    localparam int CTL_RXB  = 5;
    localparam int CTL_TXB  = 4;
    localparam int CTL_EXEN = 3;
    localparam int CTL_RUN  = 2;
    localparam int CTL_CT   = 1;
    localparam int CTL_CAP  = 0;
endpackage

// File: rtl/crt_edge_det.sv
// Falling-edge qualifier. The pin is sampled only on machine-cycle ticks.
// An event is a tick whose sample is 0 when the previous tick's sample was 1.
// Assumes the pin is held steady around each tick.
module crt_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic fall
);
    logic samp_r;

    // Keep the pin value seen at the most recent tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            samp_r <= 1'b0;
        else if (tick)
            samp_r <= pin;
    end

    assign fall = tick & samp_r & ~pin;
endmodule

// File: rtl/crt_ctrl.sv
// Control and mode registers, sticky flags, mode decode and the interrupt.
// Hardware flag set and toggle are applied on top of a same-cycle processor write.
module crt_ctrl
    import crt_pkg::*;
#(
    parameter int CTL_W  = 8,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              mode_wr,
    input  logic [CTL_W-1:0]  wdata,
    input  logic              tf_set,
    input  logic              exf_set,
    input  logic              exf_tgl,
    output logic [CTL_W-1:0]  ctl_q,
    output logic [MODE_W-1:0] mode_q,
    output crt_mode_e         mode,
    output logic              ext_cnt,
    output logic              exen,
    output logic              dcen,
    output logic              irq
);
    logic [CTL_W-1:0]  ctl_r, ctl_n;
    logic [MODE_W-1:0] mode_r;
    logic              baud;

    // Next control value: processor write first, then hardware flag events.
    always_comb begin
        ctl_n          = ctl_wr ? wdata : ctl_r;
        ctl_n[CTL_TF]  = ctl_n[CTL_TF] | tf_set;
        ctl_n[CTL_EXF] = (ctl_n[CTL_EXF] | exf_set) ^ exf_tgl;
    end

    // Control register storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_r <= '0;
        else
            ctl_r <= ctl_n;
    end

    // Mode register storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_r <= '0;
        else if (mode_wr)
            mode_r <= wdata[MODE_W-1:0];
    end

    assign baud = ctl_r[CTL_RXB] | ctl_r[CTL_TXB];

    // Operating mode decode.
    always_comb begin
        if (!ctl_r[CTL_RUN])
            mode = MODE_OFF;
        else if (baud)
            mode = MODE_BAUD;
        else if (ctl_r[CTL_CAP])
            mode = MODE_CAPTURE;
        else
            mode = MODE_RELOAD;
    end

    assign ext_cnt = ctl_r[CTL_CT];
    assign exen    = ctl_r[CTL_EXEN];
    assign dcen    = mode_r[0];
    assign irq     = ctl_r[CTL_TF] | (ctl_r[CTL_EXF] & ~mode_r[0]);
    assign ctl_q   = ctl_r;
    assign mode_q  = mode_r;
endmodule

// File: rtl/crt_count.sv
// Count and capture/reload registers with step, wrap, capture and reload logic.
// Processor byte writes override the hardware update of the same byte.
module crt_count
    import crt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  crt_mode_e       mode,
    input  logic            ext_cnt,
    input  logic            cnt_ev,
    input  logic            trg_ev,
    input  logic            trg_lvl,
    input  logic            exen,
    input  logic            dcen,
    input  logic            wr_cnt_lo,
    input  logic            wr_cnt_hi,
    input  logic            wr_rld_lo,
    input  logic            wr_rld_hi,
    input  logic [W/2-1:0]  wdata,
    output logic [W-1:0]    count_q,
    output logic [W-1:0]    reload_q,
    output logic            wrap,
    output logic            wrap_tgl,
    output logic            trg_hit
);
    localparam int          HW   = W / 2;
    localparam logic [W-1:0] ALL1 = '1;

    logic [W-1:0] cnt_r, cnt_n, rld_r, rld_n;
    logic         step, updown, going_up, at_top, at_floor;

    assign step     = (mode != MODE_OFF) && (ext_cnt ? cnt_ev : tick);
    assign updown   = (mode == MODE_RELOAD) && dcen;
    assign going_up = !updown || trg_lvl;
    assign at_top   = (cnt_r == ALL1);
    assign at_floor = (cnt_r == rld_r);
    assign wrap     = step && (going_up ? at_top : at_floor);
    assign wrap_tgl = wrap && updown;
    assign trg_hit  = trg_ev && exen &&
                      ((mode == MODE_CAPTURE) || ((mode == MODE_RELOAD) && !updown));

    // Next count: step/wrap, trigger reload, then processor byte writes.
    always_comb begin
        cnt_n = cnt_r;
        if (step) begin
            if (going_up)
                cnt_n = at_top ? ((mode == MODE_CAPTURE) ? '0 : rld_r) : cnt_r + 1'b1;
            else
                cnt_n = at_floor ? ALL1 : cnt_r - 1'b1;
        end
        if (trg_hit && (mode == MODE_RELOAD))
            cnt_n = rld_r;
        if (wr_cnt_lo)
            cnt_n[HW-1:0] = wdata;
        if (wr_cnt_hi)
            cnt_n[W-1:HW] = wdata;
    end

    // Next capture/reload value: capture event, then processor byte writes.
    always_comb begin
        rld_n = rld_r;
        if (trg_hit && (mode == MODE_CAPTURE))
            rld_n = cnt_r;
        if (wr_rld_lo)
            rld_n[HW-1:0] = wdata;
        if (wr_rld_hi)
            rld_n[W-1:HW] = wdata;
    end

    // Count and capture/reload storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_r <= '0;
            rld_r <= '0;
        end else begin
            cnt_r <= cnt_n;
            rld_r <= rld_n;
        end
    end

    assign count_q  = cnt_r;
    assign reload_q = rld_r;
endmodule

// File: rtl/cr_updown_timer.sv
// Top level of the capture/reload timer: register decode, pin qualifiers,
// control, count datapath and the registered wrap pulse.
// Assumes mc_tick is one cycle wide and the pins are steady around each tick.
module cr_updown_timer
    import crt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NPIN  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mc_tick,
    input  logic             cnt_pin,
    input  logic             trig_pin,
    input  logic             reg_wr,
    input  logic [2:0]       reg_sel,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       ctl_q,
    output logic [1:0]       mode_q,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] reload_q,
    output logic             irq,
    output logic             ovf_pulse
);
    logic [NPIN-1:0] pins, falls;
    crt_sel_e        sel;
    crt_mode_e       mode;
    logic            ext_cnt, exen, dcen, wrap, wrap_tgl, trg_hit;
    logic            pulse_r;

    assign pins = {trig_pin, cnt_pin};
    assign sel  = crt_sel_e'(reg_sel);

    // One tick-qualified falling-edge detector per external pin.
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        crt_edge_det u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (mc_tick),
            .pin  (pins[i]),
            .fall (falls[i])
        );
    end

    crt_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_wr (reg_wr && sel == SEL_CTL),
        .mode_wr(reg_wr && sel == SEL_MODE),
        .wdata  (reg_wdata),
        .tf_set (wrap && mode != MODE_BAUD),
        .exf_set(trg_hit),
        .exf_tgl(wrap_tgl),
        .ctl_q  (ctl_q),
        .mode_q (mode_q),
        .mode   (mode),
        .ext_cnt(ext_cnt),
        .exen   (exen),
        .dcen   (dcen),
        .irq    (irq)
    );

    crt_count #(.W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (mc_tick),
        .mode     (mode),
        .ext_cnt  (ext_cnt),
        .cnt_ev   (falls[0]),
        .trg_ev   (falls[1]),
        .trg_lvl  (trig_pin),
        .exen     (exen),
        .dcen     (dcen),
        .wr_cnt_lo(reg_wr && sel == SEL_CNT_LO),
        .wr_cnt_hi(reg_wr && sel == SEL_CNT_HI),
        .wr_rld_lo(reg_wr && sel == SEL_RLD_LO),
        .wr_rld_hi(reg_wr && sel == SEL_RLD_HI),
        .wdata    (reg_wdata),
        .count_q  (count_q),
        .reload_q (reload_q),
        .wrap     (wrap),
        .wrap_tgl (wrap_tgl),
        .trg_hit  (trg_hit)
    );

    // Register the wrap as a one-cycle pulse for the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_r <= 1'b0;
        else
            pulse_r <= wrap;
    end

    assign ovf_pulse = pulse_r;
endmodule

// File: rtl/crt_checks.sv
// Temporal checks on the timer's ports, attached to the top module by bind.
module crt_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        mc_tick,
    input logic        reg_wr,
    input logic [2:0]  reg_sel,
    input logic [7:0]  ctl_q,
    input logic        dcen,
    input logic [15:0] count_q,
    input logic [15:0] reload_q,
    input logic        ovf_pulse
);
    logic cnt_write, ctl_write, baud_on, plain_up;

    assign cnt_write = reg_wr && (reg_sel == 3'd2 || reg_sel == 3'd3);
    assign ctl_write = reg_wr && (reg_sel == 3'd0);
    assign baud_on   = ctl_q[5] | ctl_q[4];
    assign plain_up  = ctl_q[2] && !ctl_q[1] && !ctl_q[0] && !baud_on && !dcen;

    // R2: a stopped timer keeps its count unless the processor writes it.
    p_hold_when_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[2] && !cnt_write) |=> $stable(count_q));

    // R2: without a tick no step can happen.
    p_no_tick_no_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mc_tick && !reg_wr) |=> $stable(count_q));

    // R4: an up step from all ones loads the reload value.
    p_reload_on_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_up && mc_tick && count_q == 16'hFFFF && !reg_wr) |=> count_q == $past(reload_q));

    // R5: the capture/reload register only changes on a tick or a write.
    p_reload_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mc_tick && !reg_wr) |=> $stable(reload_q));

    // R8: the overflow flag never rises in baud mode.
    p_baud_tf_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_on && !ctl_q[7] && !ctl_write) |=> !ctl_q[7]);

    // R9: the overflow flag is sticky until a control write.
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[7] && !ctl_write) |=> ctl_q[7]);

    // R10: a wrap pulse follows a running tick.
    p_pulse_after_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> ($past(mc_tick) && $past(ctl_q[2])));
endmodule

bind cr_updown_timer crt_checks u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mc_tick  (mc_tick),
    .reg_wr   (reg_wr),
    .reg_sel  (reg_sel),
    .ctl_q    (ctl_q),
    .dcen     (mode_q[0]),
    .count_q  (count_q),
    .reload_q (reload_q),
    .ovf_pulse(ovf_pulse)
);

// File: tb/tb_cr_updown_timer.sv
`timescale 1ns/1ps
module tb_cr_updown_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mc_tick = 1'b0;
    logic        cnt_pin = 1'b0;
    logic        trig_pin = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  ctl_q;
    logic [1:0]  mode_q;
    logic [15:0] count_q, reload_q;
    logic        irq, ovf_pulse;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cr_updown_timer dut (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .cnt_pin(cnt_pin),
        .trig_pin(trig_pin), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctl_q(ctl_q), .mode_q(mode_q),
        .count_q(count_q), .reload_q(reload_q), .irq(irq), .ovf_pulse(ovf_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) mc_tick = 1'b1;
        @(negedge clk) mc_tick = 1'b0;
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk) begin reg_wr = 1'b1; reg_sel = s; reg_wdata = d; end
        @(negedge clk) reg_wr = 1'b0;
    endtask

    task automatic tick_wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk) begin mc_tick = 1'b1; reg_wr = 1'b1; reg_sel = s; reg_wdata = d; end
        @(negedge clk) begin mc_tick = 1'b0; reg_wr = 1'b0; end
    endtask

    task automatic set16(input logic [2:0] lo_sel, input logic [15:0] v);
        wr(lo_sel, v[7:0]);
        wr(lo_sel + 3'd1, v[15:8]);
    endtask

    // Watchdog: an overrun counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int exp_i, prev_i, tot;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctl", ctl_q, 0);
        chk("R1 mode", mode_q, 0);
        chk("R1 count", count_q, 0);
        chk("R1 reload", reload_q, 0);
        chk("R1 irq", irq, 0);
        chk("R1 pulse", ovf_pulse, 0);

        // R2 timer mode stepping, holding without tick and while stopped
        wr(3'd0, 8'h04);
        for (int n = 1; n <= 20; n++) begin
            tick();
            chk("R2 step", count_q, n);
        end
        repeat (5) @(negedge clk);
        chk("R2 no tick hold", count_q, 20);
        wr(3'd0, 8'h00);
        repeat (3) tick();
        chk("R2 stopped hold", count_q, 20);

        // R4 R9 R10 auto-reload up sweep across several wraps
        set16(3'd4, 16'hFFF0);
        set16(3'd2, 16'hFFFA);
        wr(3'd0, 8'h04);
        prev_i = 'hFFFA;
        for (int n = 1; n <= 40; n++) begin
            tick();
            tot = 'hFFFA + n;
            exp_i = (tot <= 'hFFFF) ? tot : 'hFFF0 + ((tot - 'h10000) % 16);
            chk("R4 reload count", count_q, exp_i);
            chk("R10 pulse", ovf_pulse, (prev_i == 'hFFFF));
            chk("R9 tf sticky", ctl_q[7], (n >= 6));
            chk("R9 irq", irq, (n >= 6));
            prev_i = exp_i;
        end
        wr(3'd0, 8'h04);
        chk("R9 tf cleared", ctl_q[7], 0);
        chk("R9 irq cleared", irq, 0);

        // R3 counter mode with several pin patterns
        wr(3'd0, 8'h00);
        set16(3'd2, 16'h0000);
        set16(3'd4, 16'h0000);
        wr(3'd0, 8'h06);
        begin
            logic [15:0] pats [5] = '{16'hA5A5, 16'hFFFF, 16'h0000, 16'hCCCC, 16'h6DB6};
            bit prev_s = 1'b0;
            int ev = 0;
            foreach (pats[p]) begin
                for (int b = 0; b < 16; b++) begin
                    @(negedge clk) cnt_pin = pats[p][b];
                    tick();
                    if (prev_s && !pats[p][b]) ev++;
                    prev_s = pats[p][b];
                end
                chk("R3 edge count", count_q, ev);
            end
        end
        @(negedge clk) cnt_pin = 1'b0;
        tick();

        // R5 capture on trigger edge, count keeps running, wrap to zero
        wr(3'd0, 8'h00);
        @(negedge clk) trig_pin = 1'b1;
        tick();
        set16(3'd2, 16'hFFF8);
        set16(3'd4, 16'h0000);
        wr(3'd0, 8'h0D);
        repeat (3) tick();
        chk("R5 pre count", count_q, 16'hFFFB);
        @(negedge clk) trig_pin = 1'b0;
        tick();
        chk("R5 captured", reload_q, 16'hFFFB);
        chk("R5 count runs", count_q, 16'hFFFC);
        chk("R5 exf", ctl_q[6], 1);
        chk("R9 irq from exf", irq, 1);
        @(negedge clk) trig_pin = 1'b1;
        repeat (4) tick();
        chk("R5 wrap zero", count_q, 16'h0000);
        chk("R5 tf", ctl_q[7], 1);
        chk("R10 capture pulse", ovf_pulse, 1);
        chk("R5 capture kept", reload_q, 16'hFFFB);

        // R6 trigger reload, and no effect without trigger enable
        wr(3'd0, 8'h00);
        set16(3'd4, 16'h4000);
        set16(3'd2, 16'h0100);
        wr(3'd0, 8'h0C);
        repeat (2) tick();
        @(negedge clk) trig_pin = 1'b0;
        tick();
        chk("R6 reload", count_q, 16'h4000);
        chk("R6 exf ctl", ctl_q, 8'h4C);
        @(negedge clk) trig_pin = 1'b1;
        tick();
        wr(3'd0, 8'h04);
        @(negedge clk) trig_pin = 1'b0;
        tick();
        chk("R6 ignored count", count_q, 16'h4002);
        chk("R6 ignored ctl", ctl_q, 8'h04);
        @(negedge clk) trig_pin = 1'b1;
        tick();

        // R7 up/down counting with floor underflow and EXF toggle
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h01);
        chk("R7 mode", mode_q, 2'b01);
        set16(3'd4, 16'h0010);
        set16(3'd2, 16'h0013);
        @(negedge clk) trig_pin = 1'b0;
        wr(3'd0, 8'h04);
        for (int n = 1; n <= 8; n++) begin
            tick();
            exp_i = (n <= 3) ? ('h13 - n) : ('hFFFF - (n - 4));
            chk("R7 down count", count_q, exp_i);
            chk("R10 down pulse", ovf_pulse, (n == 4));
        end
        chk("R7 flags", ctl_q, 8'hC4);
        wr(3'd0, 8'h44);
        chk("R9 exf masked", irq, 0);
        @(negedge clk) trig_pin = 1'b1;
        repeat (4) tick();
        chk("R7 up count", count_q, 16'hFFFF);
        tick();
        chk("R7 up reload", count_q, 16'h0010);
        chk("R7 toggle back", ctl_q, 8'h84);
        chk("R9 irq tf", irq, 1);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h00);

        // R8 baud mode: forced reload, no TF, trigger ignored
        set16(3'd4, 16'hFFFC);
        set16(3'd2, 16'hFFFE);
        wr(3'd0, 8'h2D);
        prev_i = 'hFFFE;
        for (int n = 1; n <= 12; n++) begin
            tick();
            tot = 'hFFFE + n;
            exp_i = (tot <= 'hFFFF) ? tot : 'hFFFC + ((tot - 'h10000) % 4);
            chk("R8 baud count", count_q, exp_i);
            chk("R10 baud pulse", ovf_pulse, (prev_i == 'hFFFF));
            chk("R8 no tf", ctl_q[7], 0);
            chk("R8 no exf", ctl_q[6], 0);
            chk("R8 no capture", reload_q, 16'hFFFC);
            prev_i = exp_i;
            if (n == 5) begin
                @(negedge clk) trig_pin = 1'b0;
            end
        end

        // R11 processor byte write beats same-cycle step
        wr(3'd0, 8'h00);
        set16(3'd4, 16'h0000);
        set16(3'd2, 16'h12FF);
        wr(3'd0, 8'h04);
        tick_wr(3'd2, 8'h55);
        chk("R11 low byte", count_q, 16'h1355);
        tick_wr(3'd3, 8'hAB);
        chk("R11 high byte", count_q, 16'hAB56);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule